// File: doc/BRIEF.md
# Two-Way Set-Associative Cache Controller

This block is a data cache with two ways per set. It sits between a processor port that moves one word per access and a memory port that moves one whole line per transfer. The byte address of a processor access is cut into three fields. The lowest bits pick a byte within the line. The middle bits choose a set. The top bits form the tag, which is matched against the tags stored in both ways of that set at once.

A hit returns the addressed word in the cycle it is requested, or writes that word into the line. A miss holds the processor port off while the controller works through the miss. First it picks a way to replace. An empty way is taken first. Otherwise the way is chosen by the replacement policy: least-recently-used or oldest-filled, selected by a run-time input. A modified victim is written back to memory, the wanted line is read in, and the held access then completes as a hit.

A second run-time input selects the write policy. In write-through mode every write also sends the updated line to memory. In write-back mode only the cache copy changes until the line is replaced. Both modes allocate a line on a write miss.

Top module: `cache2w_ctrl`

## Requirements
- R1: After reset every line is invalid; with no request pending, cpu_ready and mem_req are low, and the first access to any address misses.
- R2: With WOFF_W = log2(WORD_W/8) and OFF_W = log2(BLOCK_BYTES), address bits [OFF_W-1:WOFF_W] select the word in the line, the next log2(SETS) bits select the set, and the rest form the tag. A read that matches a valid way in either way of the set raises cpu_ready in the same cycle with the word on cpu_rdata and no memory request.
- R3: On a read miss with a clean or empty victim, the controller issues one line read (mem_we = 0) at block address cpu_addr >> OFF_W. When mem_ack arrives the line is stored, and the held read completes in the following cycle with the word from that line.
- R4: On a write miss the line is first read from memory, and the write is then applied to it; a later read of that word returns the written value.
- R5: With cfg_write_back = 0, every completed write drives a line write (mem_we = 1) of the updated line to the line's block address, and cpu_ready rises together with mem_ack. Lines written this way are not modified and are never written back on replacement.
- R6: With cfg_write_back = 1, a write hit completes in its request cycle with no memory request and marks the line modified. When a modified line is replaced, the whole line is written to its own block address, and the line read for the new address follows.
- R7: Replacing an unmodified line causes no memory write.
- R8: A miss in a set with an invalid way fills that way, way 0 before way 1, and leaves any valid line of that set in place.
- R9: With cfg_repl_lru = 1 and both ways valid, the victim is the way that was not accessed by the most recent completed access to that set.
- R10: With cfg_repl_lru = 0 and both ways valid, the victim is the way that was filled less recently; hits do not change this choice.
- R11: A memory request keeps mem_req, mem_we and mem_addr unchanged until mem_ack is seen, and memory transfers occur strictly one at a time in the order of the miss sequence.
- R12: cpu_ready stays low for the whole miss sequence, and never rises while a line read is outstanding. The processor holds cpu_we, cpu_addr and cpu_wdata steady while cpu_req is high and cpu_ready is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cfg_write_back | input | 1 | 1 = write-back, 0 = write-through |
| cfg_repl_lru | input | 1 | 1 = least-recently-used victim, 0 = oldest-filled victim |
| cpu_req | input | 1 | Processor access request, held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address of the access |
| cpu_wdata | input | WORD_W | Write word |
| cpu_ready | output | 1 | Access completes at this clock edge |
| cpu_rdata | output | WORD_W | Read word, valid with cpu_ready on a read |
| mem_req | output | 1 | Memory line transfer request |
| mem_we | output | 1 | 1 = line write, 0 = line read |
| mem_addr | output | ADDR_W - log2(BLOCK_BYTES) | Block address of the line |
| mem_wdata | output | BLOCK_BYTES*8 | Line to be written |
| mem_ack | input | 1 | One-cycle completion of the current transfer |
| mem_rdata | input | BLOCK_BYTES*8 | Line read, valid with mem_ack |

## Verification
The bench builds the controller with four sets, 16-byte lines of four 32-bit words, and a 16-bit address. With these values, a handful of tags all land in one set. That makes conflicts, dirty evictions and the divergence between the two replacement policies reachable in a few accesses, with every expected memory transfer written out by hand. The small line width also lets the memory model hold and compare whole lines directly. A modified word can then be traced through eviction and refill back to the processor.

// File: rtl/cache2w_pkg.sv
`timescale 1ns/1ps
package cache2w_pkg;

    localparam int WAYS = 2;

    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_FILL   = 2'd2
    } ctrl_state_e;

    // Empty ways first (way 0 before way 1), then the policy's pick.
    function automatic logic pick_victim(
        input logic [WAYS-1:0] valid,
        input logic            use_lru,
        input logic            lru_old,
        input logic            fifo_old
    );
        if (!valid[0])      return 1'b0;
        else if (!valid[1]) return 1'b1;
        return use_lru ? lru_old : fifo_old;
    endfunction

endpackage

// File: rtl/cache2w_tag_store.sv
`timescale 1ns/1ps
module cache2w_tag_store
    import cache2w_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int TAG_W = 20
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic [$clog2(SETS)-1:0]    idx,
    input  logic [TAG_W-1:0]           cmp_tag,
    output logic [WAYS-1:0]            hit_vec,
    output logic [WAYS-1:0]            valid_vec,
    output logic [WAYS-1:0]            dirty_vec,
    output logic [WAYS-1:0][TAG_W-1:0] tag_vec,
    input  logic                       fill_en,
    input  logic                       fill_way,
    input  logic                       mark_en,
    input  logic                       mark_way
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [TAG_W-1:0] tags [SETS];
        logic [SETS-1:0]  vld;
        logic [SETS-1:0]  drt;

        always_ff @(posedge clk) begin
            if (rst) begin
                vld <= '0;
                drt <= '0;
            end else if (fill_en && fill_way == 1'(w)) begin
                vld[idx] <= 1'b1;
                drt[idx] <= 1'b0;
            end else if (mark_en && mark_way == 1'(w)) begin
                drt[idx] <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (fill_en && fill_way == 1'(w)) begin
                tags[idx] <= cmp_tag;
            end
        end

        assign valid_vec[w] = vld[idx];
        assign dirty_vec[w] = drt[idx];
        assign tag_vec[w]   = tags[idx];
        assign hit_vec[w]   = vld[idx] && (tags[idx] == cmp_tag);
    end

endmodule

// File: rtl/cache2w_data_store.sv
`timescale 1ns/1ps
module cache2w_data_store
    import cache2w_pkg::*;
#(
    parameter int SETS  = 8,
    parameter int BLK_W = 512
) (
    input  logic                       clk,
    input  logic [$clog2(SETS)-1:0]    idx,
    output logic [WAYS-1:0][BLK_W-1:0] line_vec,
    input  logic                       wr_en,
    input  logic                       wr_way,
    input  logic [BLK_W-1:0]           wr_line
);

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [BLK_W-1:0] lines [SETS];

        always_ff @(posedge clk) begin
            if (wr_en && wr_way == 1'(w)) begin
                lines[idx] <= wr_line;
            end
        end

        assign line_vec[w] = lines[idx];
    end

endmodule

// File: rtl/cache2w_repl.sv
`timescale 1ns/1ps
module cache2w_repl
    import cache2w_pkg::*;
#(
    parameter int SETS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [$clog2(SETS)-1:0] idx,
    input  logic                    use_lru,
    input  logic [WAYS-1:0]         valid_vec,
    output logic                    victim_way,
    input  logic                    touch_en,
    input  logic                    touch_way,
    input  logic                    fill_en,
    input  logic                    fill_way
);

    // Per set: way not used last, and way not filled last.
    logic [SETS-1:0] lru_old;
    logic [SETS-1:0] fifo_old;

    always_ff @(posedge clk) begin
        if (rst) begin
            lru_old  <= '0;
            fifo_old <= '0;
        end else begin
            if (touch_en) lru_old[idx]  <= ~touch_way;
            if (fill_en)  fifo_old[idx] <= ~fill_way;
        end
    end

    assign victim_way = pick_victim(valid_vec, use_lru, lru_old[idx], fifo_old[idx]);

endmodule

// File: rtl/cache2w_ctrl.sv
`timescale 1ns/1ps
module cache2w_ctrl
    import cache2w_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int WORD_W      = 32,
    parameter int BLOCK_BYTES = 64,
    parameter int SETS        = 8
) (
    input  logic                                    clk,
    input  logic                                    rst,
    input  logic                                    cfg_write_back,
    input  logic                                    cfg_repl_lru,
    input  logic                                    cpu_req,
    input  logic                                    cpu_we,
    input  logic [ADDR_W-1:0]                       cpu_addr,
    input  logic [WORD_W-1:0]                       cpu_wdata,
    output logic                                    cpu_ready,
    output logic [WORD_W-1:0]                       cpu_rdata,
    output logic                                    mem_req,
    output logic                                    mem_we,
    output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0]   mem_addr,
    output logic [BLOCK_BYTES*8-1:0]                mem_wdata,
    input  logic                                    mem_ack,
    input  logic [BLOCK_BYTES*8-1:0]                mem_rdata
);

    localparam int BLK_W   = BLOCK_BYTES * 8;
    localparam int OFF_W   = $clog2(BLOCK_BYTES);
    localparam int WOFF_W  = $clog2(WORD_W / 8);
    localparam int WSEL_W  = OFF_W - WOFF_W;
    localparam int IDX_W   = $clog2(SETS);
    localparam int TAG_W   = ADDR_W - OFF_W - IDX_W;

    // Address fields
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [WSEL_W-1:0] wsel;
    logic              unused_byte_bits;

    assign idx  = cpu_addr[OFF_W +: IDX_W];
    assign tag  = cpu_addr[ADDR_W-1 -: TAG_W];
    assign wsel = cpu_addr[WOFF_W +: WSEL_W];
    assign unused_byte_bits = ^cpu_addr[WOFF_W-1:0];

    // Lookup state
    logic [WAYS-1:0]            hit_vec, valid_vec, dirty_vec;
    logic [WAYS-1:0][TAG_W-1:0] tag_vec;
    logic [WAYS-1:0][BLK_W-1:0] line_vec;
    logic                       hit, hit_way, victim_way;
    logic [BLK_W-1:0]           cur_line, merged_line;

    ctrl_state_e state;
    logic        vic_way;

    logic in_lookup, access_hit, fill_done, cpu_write_done;
    logic data_wr_en, data_wr_way;
    logic [BLK_W-1:0] data_wr_line;

    assign hit     = |hit_vec;
    assign hit_way = hit_vec[1];

    assign cur_line  = line_vec[hit_way];
    assign cpu_rdata = cur_line[wsel*WORD_W +: WORD_W];

    always_comb begin
        merged_line = cur_line;
        merged_line[wsel*WORD_W +: WORD_W] = cpu_wdata;
    end

    assign in_lookup  = (state == ST_LOOKUP);
    assign access_hit = in_lookup && cpu_req && hit;
    assign cpu_ready  = access_hit && (!cpu_we || cfg_write_back || mem_ack);
    assign fill_done  = (state == ST_FILL) && mem_ack;
    assign cpu_write_done = cpu_ready && cpu_we;

    // Memory port
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = {tag, idx};
        mem_wdata = merged_line;
        unique case (state)
            ST_LOOKUP: begin
                mem_req = access_hit && cpu_we && !cfg_write_back;
                mem_we  = 1'b1;
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {tag_vec[vic_way], idx};
                mem_wdata = line_vec[vic_way];
            end
            ST_FILL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b0;
                mem_wdata = '0;
            end
            default: begin
                mem_req = 1'b0;
            end
        endcase
    end

    // Miss sequencer
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_LOOKUP;
            vic_way <= 1'b0;
        end else begin
            unique case (state)
                ST_LOOKUP: begin
                    if (cpu_req && !hit) begin
                        vic_way <= victim_way;
                        state   <= (valid_vec[victim_way] && dirty_vec[victim_way])
                                   ? ST_EVICT : ST_FILL;
                    end
                end
                ST_EVICT: if (mem_ack) state <= ST_FILL;
                ST_FILL:  if (mem_ack) state <= ST_LOOKUP;
                default:  state <= ST_LOOKUP;
            endcase
        end
    end

    // Line storage write select
    assign data_wr_en   = fill_done || cpu_write_done;
    assign data_wr_way  = fill_done ? vic_way : hit_way;
    assign data_wr_line = fill_done ? mem_rdata : merged_line;

    cache2w_tag_store #(
        .SETS  (SETS),
        .TAG_W (TAG_W)
    ) tag_i (
        .clk       (clk),
        .rst       (rst),
        .idx       (idx),
        .cmp_tag   (tag),
        .hit_vec   (hit_vec),
        .valid_vec (valid_vec),
        .dirty_vec (dirty_vec),
        .tag_vec   (tag_vec),
        .fill_en   (fill_done),
        .fill_way  (vic_way),
        .mark_en   (cpu_write_done && cfg_write_back),
        .mark_way  (hit_way)
    );

    cache2w_data_store #(
        .SETS  (SETS),
        .BLK_W (BLK_W)
    ) data_i (
        .clk      (clk),
        .idx      (idx),
        .line_vec (line_vec),
        .wr_en    (data_wr_en),
        .wr_way   (data_wr_way),
        .wr_line  (data_wr_line)
    );

    cache2w_repl #(
        .SETS (SETS)
    ) repl_i (
        .clk        (clk),
        .rst        (rst),
        .idx        (idx),
        .use_lru    (cfg_repl_lru),
        .valid_vec  (valid_vec),
        .victim_way (victim_way),
        .touch_en   (cpu_ready),
        .touch_way  (hit_way),
        .fill_en    (fill_done),
        .fill_way   (vic_way)
    );

endmodule

// File: rtl/cache2w_chk.sv
`timescale 1ns/1ps
module cache2w_chk #(
    parameter int ADDR_W      = 32,
    parameter int BLOCK_BYTES = 64
) (
    input logic                                  clk,
    input logic                                  rst,
    input logic                                  cfg_write_back,
    input logic                                  cpu_req,
    input logic                                  cpu_we,
    input logic                                  cpu_ready,
    input logic                                  mem_req,
    input logic                                  mem_we,
    input logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] mem_addr,
    input logic                                  mem_ack
);

    // R5: a write-through write finishes only with its memory write
    a_r5_wt_write_reaches_mem: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ready && !cfg_write_back) |-> (mem_req && mem_we && mem_ack));

    // R6: a write-back write hit makes no memory traffic
    a_r6_wb_write_silent: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_we && cpu_ready && cfg_write_back) |-> !mem_req);

    // R6: an eviction write is followed by the line read
    a_r6_evict_then_fill: assert property (@(posedge clk) disable iff (rst)
        (mem_req && mem_we && mem_ack && !cpu_ready) |=> (mem_req && !mem_we));

    // R11: a pending memory request holds until acknowledged
    a_r11_mem_hold: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R12: no completion while a line read is outstanding
    a_r12_stall_on_fill: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we) |-> !cpu_ready);

endmodule

bind cache2w_ctrl cache2w_chk #(
    .ADDR_W      (ADDR_W),
    .BLOCK_BYTES (BLOCK_BYTES)
) chk_i (
    .clk            (clk),
    .rst            (rst),
    .cfg_write_back (cfg_write_back),
    .cpu_req        (cpu_req),
    .cpu_we         (cpu_we),
    .cpu_ready      (cpu_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .mem_ack        (mem_ack)
);

// File: tb/cache2w_ctrl_tb_top.sv
`timescale 1ns/1ps
module cache2w_ctrl_tb_top;

    localparam int AW  = 16;
    localparam int WW  = 32;
    localparam int BB  = 16;
    localparam int NS  = 4;
    localparam int BW  = BB * 8;
    localparam int BAW = AW - 4;
    localparam int LAT = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           cfg_write_back = 1'b1;
    logic           cfg_repl_lru = 1'b1;
    logic           cpu_req = 1'b0;
    logic           cpu_we = 1'b0;
    logic [AW-1:0]  cpu_addr = '0;
    logic [WW-1:0]  cpu_wdata = '0;
    logic           cpu_ready;
    logic [WW-1:0]  cpu_rdata;
    logic           mem_req;
    logic           mem_we;
    logic [BAW-1:0] mem_addr;
    logic [BW-1:0]  mem_wdata;
    logic           mem_ack = 1'b0;
    logic [BW-1:0]  mem_rdata = '0;

    always #2 clk = ~clk;

    cache2w_ctrl #(
        .ADDR_W(AW), .WORD_W(WW), .BLOCK_BYTES(BB), .SETS(NS)
    ) dut_i (
        .clk(clk), .rst(rst),
        .cfg_write_back(cfg_write_back), .cfg_repl_lru(cfg_repl_lru),
        .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;

    typedef struct { bit is_rd; logic [WW-1:0] data; string req; } cpu_exp_t;
    typedef struct { bit we; logic [BAW-1:0] blk; string req; } mem_exp_t;
    cpu_exp_t cpu_q[$];
    mem_exp_t mem_q[$];

    logic [WW-1:0] ref_word  [int];
    logic [BW-1:0] mem_store [int];

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [WW-1:0] dflt_word(input int waddr);
        return 32'h5A00_0000 + 32'(waddr);
    endfunction

    function automatic logic [WW-1:0] ref_read(input int waddr);
        return ref_word.exists(waddr) ? ref_word[waddr] : dflt_word(waddr);
    endfunction

    function automatic logic [BW-1:0] mem_line(input int blk);
        logic [BW-1:0] l;
        if (mem_store.exists(blk)) return mem_store[blk];
        for (int w = 0; w < BB / 4; w++) l[w*WW +: WW] = dflt_word(blk * 4 + w);
        return l;
    endfunction

    // Expected memory transfer: tag t, set s
    task automatic exp_mem(input bit we, input int t, input int s, input string req);
        mem_exp_t e;
        e.we = we; e.blk = BAW'((t << 2) | s); e.req = req;
        mem_q.push_back(e);
    endtask

    // Driver: one processor access, expectation pushed to the scoreboard
    task automatic access(input bit we, input int t, input int s, input int w,
                          input logic [WW-1:0] d, input bit fast, input string req);
        cpu_exp_t e;
        int waits;
        int a;
        a = (t << 6) | (s << 4) | (w << 2);
        if (we) ref_word[a >> 2] = d;
        e.is_rd = !we; e.data = ref_read(a >> 2); e.req = req;
        cpu_q.push_back(e);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = AW'(a); cpu_wdata = d;
        #0.5;
        waits = 0;
        while (!cpu_ready && waits < 200) begin
            @(negedge clk);
            #0.5;
            waits++;
        end
        check(fast ? (waits == 0) : (waits > 0 && waits < 200), req,
              fast ? "hit latency" : "miss stall", 64'(waits), fast ? 64'd0 : 64'd1);
        @(posedge clk);
    endtask

    task automatic go_idle();
        @(negedge clk);
        cpu_req = 1'b0; cpu_we = 1'b0;
    endtask

    // Monitor: processor completions
    always @(negedge clk) begin
        #1;
        if (!rst && cpu_req && cpu_ready) begin
            if (cpu_q.size() == 0) begin
                check(1'b0, "R2", "unexpected completion", 64'(cpu_addr), 64'd0);
            end else begin
                cpu_exp_t e;
                e = cpu_q.pop_front();
                if (e.is_rd) check(cpu_rdata == e.data, e.req, "read data", 64'(cpu_rdata), 64'(e.data));
            end
        end
    end

    // Memory model and monitor of memory transfers
    int wcnt = 0;
    always @(posedge clk) begin
        #0.5;
        if (rst) begin
            mem_ack = 1'b0;
            wcnt = 0;
        end else if (mem_ack) begin
            mem_ack = 1'b0;
        end else if (mem_req) begin
            if (wcnt == LAT) begin
                wcnt = 0;
                mem_ack = 1'b1;
                if (mem_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected memory transfer", {51'd0, mem_we, mem_addr}, 64'd0);
                end else begin
                    mem_exp_t e;
                    e = mem_q.pop_front();
                    check(mem_we == e.we && mem_addr == e.blk, e.req, "memory transfer",
                          {51'd0, mem_we, mem_addr}, {51'd0, e.we, e.blk});
                end
                if (mem_we) mem_store[int'(mem_addr)] = mem_wdata;
                else        mem_rdata = mem_line(int'(mem_addr));
            end else begin
                wcnt++;
            end
        end
    end

    initial begin
        #(4 * 20000);
        if (!finished) begin
            check(1'b0, "R12", "watchdog expired", 64'd0, 64'd1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #0.5;
        check(cpu_ready == 1'b0 && mem_req == 1'b0, "R1", "idle after reset",
              {62'd0, cpu_ready, mem_req}, 64'd0);

        // Write-back, LRU; everything in set 1
        exp_mem(0, 1, 1, "R3");
        access(0, 1, 1, 0, '0, 0, "R12");                    // first access misses (R1)
        access(0, 1, 1, 2, '0, 1, "R2");                     // hit, same cycle
        exp_mem(0, 2, 1, "R4");
        access(1, 2, 1, 1, 32'hDEAD_0001, 0, "R4");          // write miss allocates
        access(0, 2, 1, 1, '0, 1, "R4");                     // read back written word
        access(0, 1, 1, 0, '0, 1, "R8");                     // first line kept, second way used
        exp_mem(1, 2, 1, "R6");                              // dirty victim out first
        exp_mem(0, 3, 1, "R9");                              // least recently used way replaced
        access(0, 3, 1, 0, '0, 0, "R9");
        exp_mem(0, 2, 1, "R7");                              // clean victim, no write
        access(0, 2, 1, 1, '0, 0, "R6");                     // written word survives writeback

        // Oldest-filled replacement
        cfg_repl_lru = 1'b0;
        access(0, 3, 1, 0, '0, 1, "R10");                    // hit does not protect it
        exp_mem(0, 4, 1, "R10");
        access(0, 4, 1, 3, '0, 0, "R10");
        access(0, 2, 1, 1, '0, 1, "R10");                    // more recent fill kept
        exp_mem(0, 3, 1, "R10");
        access(0, 3, 1, 0, '0, 0, "R10");

        // Write-through
        cfg_write_back = 1'b0;
        exp_mem(1, 3, 1, "R5");
        access(1, 3, 1, 2, 32'hBEEF_0002, 0, "R5");
        access(0, 3, 1, 2, '0, 1, "R5");
        exp_mem(0, 5, 2, "R4");
        exp_mem(1, 5, 2, "R5");
        access(1, 5, 2, 0, 32'hCAFE_0003, 0, "R4");
        access(0, 5, 2, 0, '0, 1, "R4");

        // Back to write-back, LRU
        cfg_write_back = 1'b1;
        cfg_repl_lru = 1'b1;
        access(0, 4, 1, 3, '0, 1, "R9");
        exp_mem(0, 6, 1, "R7");                              // line written through is clean
        access(0, 6, 1, 0, '0, 0, "R7");
        exp_mem(0, 3, 1, "R5");
        access(0, 3, 1, 2, '0, 0, "R5");                     // memory holds written-through word
        access(1, 6, 1, 1, 32'hF00D_0004, 1, "R6");          // write hit, no traffic
        access(0, 6, 1, 1, '0, 1, "R6");
        go_idle();

        repeat (10) @(posedge clk);
        check(mem_q.size() == 0, "R11", "memory transfers outstanding", 64'(mem_q.size()), 64'd0);
        check(cpu_q.size() == 0, "R12", "completions outstanding", 64'(cpu_q.size()), 64'd0);
        finished = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule